// File: doc/BRIEF.md
# Lockable Security Page Erase Controller

This block decides whether an erase of one of three small security pages may run, and then times it. It sits behind a serial command front end that has already decoded the traffic. That front end reports four kinds of event. A write-enable command. The release of chip select after an erase-security-page command, together with the 24-bit address and the number of address bits clocked in. A request to program lock bits. And, implicitly, status polls, which only read the outputs.

The controller keeps the write-enable latch and one set-only lock bit per page. When an erase release arrives, it checks the latch, the exact bit count, the page-select field and that page's lock bit. It then either starts a self-timed erase or aborts it.

- An abort clears the write-enable latch and touches no page.
- A started erase holds the busy flag for a fixed number of cycles set by a parameter.
- In the last busy cycle it emits a wipe strobe with the page number, which tells the storage array to fill that page with ones.
- Lock bits reset to zero here; loading them from non-volatile storage happens outside this block.

Top module: `secpg_erase_ctrl`

## Requirements
- R1: After reset, `busy_o`, `wel_o`, `wipe_stb_o` and all bits of `lock_o` are 0.
- R2: A `wren_i` pulse while idle sets `wel_o` to 1 from the next cycle on.
- R3: An erase release while `wel_o` is 0 is ignored: `busy_o` stays 0 and no wipe strobe appears.
- R4: An erase release whose bit count is not exactly 24 aborts. `wel_o` is 0 from the next cycle and `busy_o` stays 0.
- R5: The page is chosen by address bits 9:8. Value 1, 2 or 3 selects page 1, 2 or 3, and `wipe_page_o` carries that value. Value 0 aborts and clears `wel_o`. No other address bit changes the outcome.
- R6: An erase release aimed at a page whose lock bit is set aborts. `wel_o` clears and `busy_o` stays 0. `lock_o` bit k belongs to page k+1.
- R7: A valid erase raises `busy_o` in the cycle after the release and holds it for exactly ERASE_CYC cycles. `wipe_stb_o` is high only in the last of those cycles.
- R8: `wel_o` stays 1 while the erase runs and is 0 in the first idle cycle after it.
- R9: A lock request while idle with `wel_o` set ORs `lock_set_i` into `lock_o` and clears `wel_o`. Without `wel_o` the request is ignored. A set lock bit never returns to 0 except through reset.
- R10: While `busy_o` is 1, `wren_i`, erase releases and lock requests are ignored. `lock_o` does not change, and the running erase keeps its length and page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_i | input | 1 | Write-enable command event (one-cycle pulse) |
| ers_rel_i | input | 1 | Chip-select release after an erase-security-page command (one-cycle pulse) |
| ers_addr_i | input | 24 | Address received with the erase command |
| ers_bits_i | input | 6 | Number of address bits clocked in before the release |
| lock_req_i | input | 1 | Lock-bit programming event (one-cycle pulse) |
| lock_set_i | input | 3 | Lock bits to set; bit k belongs to page k+1 |
| busy_o | output | 1 | Erase in progress status bit |
| wel_o | output | 1 | Write-enable latch status bit |
| lock_o | output | 3 | Current lock bits |
| wipe_stb_o | output | 1 | One-cycle strobe: fill the selected page with ones |
| wipe_page_o | output | 2 | Page number (1 to 3) qualified by `wipe_stb_o` |

## Verification
The bit-count input is swept from 0 to 40 with the latch set. Only a count of 24 may start an erase, which separates an exact-length check from a minimum-length check and from an off-by-one.

The page field is swept over all four values, crossed with several patterns in the undecoded address bits. This shows that only bits 9:8 steer the outcome and that value 0 takes the abort path.

The lock state is swept across pages, and the latch is toggled between tries. This separates the three gates: a missing latch leaves it cleared silently, while an abort clears a set latch. Noise is injected in the middle of an erase to show that the running erase keeps its length and page and that the lock bits are untouched.

// File: rtl/secpg_pkg.sv
package secpg_pkg;
    localparam int ADDR_W   = 24;
    localparam int BCNT_W   = 6;
    localparam int NPAGE    = 3;
    localparam int PSEL_LSB = 8;
    localparam int PSEL_W   = 2;

    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_START = 2'd1,
        VD_ABORT = 2'd2
    } verdict_e;

    typedef struct packed {
        logic              rel;
        logic [ADDR_W-1:0] addr;
        logic [BCNT_W-1:0] bits;
    } erase_req_t;

    function automatic logic [PSEL_W-1:0] page_field(input logic [ADDR_W-1:0] a);
        return a[PSEL_LSB +: PSEL_W];
    endfunction
endpackage

// File: rtl/secpg_lock_bank.sv
module secpg_lock_bank
    import secpg_pkg::*;
#(
    parameter int N = NPAGE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic [N-1:0] set_mask,
    output logic [N-1:0] lock
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        logic lb_q;
        always_ff @(posedge clk) begin
            if (rst)
                lb_q <= 1'b0;
            else if (set_en && set_mask[k])
                lb_q <= 1'b1;
        end
        assign lock[k] = lb_q;
    end
endmodule

// File: rtl/secpg_gate.sv
module secpg_gate
    import secpg_pkg::*;
(
    input  erase_req_t        req,
    input  logic              wel,
    input  logic              busy,
    input  logic [NPAGE-1:0]  lock,
    output verdict_e          verdict,
    output logic [PSEL_W-1:0] page
);
    localparam logic [BCNT_W-1:0] FULL_BITS = BCNT_W'(ADDR_W);

    logic page_locked;

    always_comb begin
        page        = page_field(req.addr);
        page_locked = 1'b0;
        for (int k = 0; k < NPAGE; k++)
            if (page == PSEL_W'(k + 1) && lock[k])
                page_locked = 1'b1;
    end

    always_comb begin
        verdict = VD_NONE;
        if (req.rel && !busy && wel) begin
            if (req.bits != FULL_BITS || page == '0 || page_locked)
                verdict = VD_ABORT;
            else
                verdict = VD_START;
        end
    end
endmodule

// File: rtl/secpg_erase_timer.sv
module secpg_erase_timer
    import secpg_pkg::*;
#(
    parameter int ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PSEL_W-1:0] page_in,
    output logic              busy,
    output logic              done,
    output logic [PSEL_W-1:0] page_q
);
    localparam int CW = $clog2(ERASE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(ERASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            page_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0)
                busy <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            cnt_q  <= LAST;
            page_q <= page_in;
        end
    end

    assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/secpg_erase_ctrl.sv
module secpg_erase_ctrl
    import secpg_pkg::*;
#(
    parameter int ERASE_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wren_i,
    input  logic        ers_rel_i,
    input  logic [23:0] ers_addr_i,
    input  logic [5:0]  ers_bits_i,
    input  logic        lock_req_i,
    input  logic [2:0]  lock_set_i,
    output logic        busy_o,
    output logic        wel_o,
    output logic [2:0]  lock_o,
    output logic        wipe_stb_o,
    output logic [1:0]  wipe_page_o
);
    erase_req_t        req;
    verdict_e          verdict;
    logic [PSEL_W-1:0] sel_page;
    logic              done;
    logic              wel_q;
    logic              lock_go;
    logic [NPAGE-1:0]  lock_w;

    assign req.rel  = ers_rel_i;
    assign req.addr = ers_addr_i;
    assign req.bits = ers_bits_i;

    secpg_gate u_gate (
        .req     (req),
        .wel     (wel_q),
        .busy    (busy_o),
        .lock    (lock_w),
        .verdict (verdict),
        .page    (sel_page)
    );

    secpg_erase_timer #(.ERASE_CYC(ERASE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (verdict == VD_START),
        .page_in (sel_page),
        .busy    (busy_o),
        .done    (done),
        .page_q  (wipe_page_o)
    );

    assign lock_go = lock_req_i && !busy_o && wel_q && !ers_rel_i;

    secpg_lock_bank #(.N(NPAGE)) u_locks (
        .clk      (clk),
        .rst      (rst),
        .set_en   (lock_go),
        .set_mask (lock_set_i),
        .lock     (lock_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            wel_q <= 1'b0;
        else if (done)
            wel_q <= 1'b0;
        else if (!busy_o) begin
            if (verdict == VD_ABORT)
                wel_q <= 1'b0;
            else if (lock_go)
                wel_q <= 1'b0;
            else if (wren_i && !ers_rel_i && !lock_req_i)
                wel_q <= 1'b1;
        end
    end

    assign wel_o      = wel_q;
    assign lock_o     = lock_w;
    assign wipe_stb_o = done;
endmodule

// File: rtl/secpg_erase_chk.sv
module secpg_erase_chk #(
    parameter int ERASE_CYC = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       busy_o,
    input logic       wel_o,
    input logic [2:0] lock_o,
    input logic       wipe_stb_o
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= 0;
        else if (busy_o)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(wel_o));

    assert_erase_length_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> run_len == ERASE_CYC);

    assert_strobe_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(wipe_stb_o));

    assert_wel_during_erase_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !wipe_stb_o) |-> wel_o);

    assert_wel_cleared_after_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> !wel_o);

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (($past(lock_o) & ~lock_o) == 3'b000));

    assert_lock_frozen_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(lock_o));
endmodule

bind secpg_erase_ctrl secpg_erase_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .wel_o      (wel_o),
    .lock_o     (lock_o),
    .wipe_stb_o (wipe_stb_o)
);

// File: tb/secpg_erase_ctrl_bench.sv
module secpg_erase_ctrl_bench;
    localparam int E = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wren_i = 1'b0;
    logic        ers_rel_i = 1'b0;
    logic [23:0] ers_addr_i = '0;
    logic [5:0]  ers_bits_i = '0;
    logic        lock_req_i = 1'b0;
    logic [2:0]  lock_set_i = '0;
    logic        busy_o, wel_o, wipe_stb_o;
    logic [2:0]  lock_o;
    logic [1:0]  wipe_page_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    secpg_erase_ctrl #(.ERASE_CYC(E)) u_secpg_erase_ctrl (
        .clk(clk), .rst(rst), .wren_i(wren_i), .ers_rel_i(ers_rel_i),
        .ers_addr_i(ers_addr_i), .ers_bits_i(ers_bits_i),
        .lock_req_i(lock_req_i), .lock_set_i(lock_set_i),
        .busy_o(busy_o), .wel_o(wel_o), .lock_o(lock_o),
        .wipe_stb_o(wipe_stb_o), .wipe_page_o(wipe_page_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic set_wel();
        wren_i = 1'b1;
        tick();
        wren_i = 1'b0;
        check("R2 wel set", int'(wel_o), 1);
    endtask

    task automatic do_lock(input logic [2:0] m);
        lock_set_i = m;
        lock_req_i = 1'b1;
        tick();
        lock_req_i = 1'b0;
        lock_set_i = '0;
    endtask

    // start: expected outcome; pg: expected page; noise: inject commands mid-erase
    task automatic do_erase(input logic [23:0] a, input logic [5:0] b, input bit start,
                            input int pg, input bit noise, input bit exp_wel, input string rq);
        logic [2:0] lk;
        lk = lock_o;
        ers_addr_i = a;
        ers_bits_i = b;
        ers_rel_i = 1'b1;
        tick();
        ers_rel_i = 1'b0;
        if (start) begin
            for (int i = 0; i < E; i++) begin
                check({rq, " R7 busy"}, int'(busy_o), 1);
                check({rq, " R8 wel during"}, int'(wel_o), 1);
                check({rq, " R7 strobe"}, int'(wipe_stb_o), (i == E - 1) ? 1 : 0);
                if (i == E - 1) check({rq, " R5 page"}, int'(wipe_page_o), pg);
                if (noise && i == 1) begin
                    wren_i = 1'b1; lock_req_i = 1'b1; lock_set_i = 3'b111;
                    ers_rel_i = 1'b1; ers_bits_i = 6'd24;
                    ers_addr_i = 24'h000100 ^ {14'd0, 2'(pg), 8'd0} ^ 24'h000300;
                end
                tick();
                wren_i = 1'b0; lock_req_i = 1'b0; lock_set_i = '0; ers_rel_i = 1'b0;
            end
            check({rq, " R7 idle after"}, int'(busy_o), 0);
            check({rq, " R8 wel after"}, int'(wel_o), 0);
            if (noise) check({rq, " R10 lock untouched"}, int'(lock_o), int'(lk));
        end else begin
            check({rq, " no busy"}, int'(busy_o), 0);
            check({rq, " wel"}, int'(wel_o), int'(exp_wel));
            check({rq, " no strobe"}, int'(wipe_stb_o), 0);
        end
    endtask

    initial begin
        logic [7:0]  lows [3];
        logic [13:0] highs [3];
        lows[0] = 8'h00; lows[1] = 8'hA5; lows[2] = 8'hFF;
        highs[0] = 14'h0000; highs[1] = 14'h2AAA; highs[2] = 14'h3FFF;

        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 busy", int'(busy_o), 0);
        check("R1 wel", int'(wel_o), 0);
        check("R1 lock", int'(lock_o), 0);
        check("R1 strobe", int'(wipe_stb_o), 0);

        // R3: no write enable -> ignored
        do_erase(24'h000100, 6'd24, 0, 0, 0, 0, "R3 no wel");

        // R4: bit count sweep
        for (int b = 0; b <= 40; b++) begin
            set_wel();
            if (b == 24)
                do_erase(24'h000100, 6'(b), 1, 1, 0, 0, "R4 exact count");
            else
                do_erase(24'h000100, 6'(b), 0, 0, 0, 0, "R4 bad count");
        end

        // R5: page field crossed with undecoded bits
        for (int p = 0; p < 4; p++)
            for (int h = 0; h < 3; h++)
                for (int l = 0; l < 3; l++) begin
                    set_wel();
                    if (p == 0)
                        do_erase({highs[h], 2'd0, lows[l]}, 6'd24, 0, 0, 0, 0, "R5 page0");
                    else
                        do_erase({highs[h], 2'(p), lows[l]}, 6'd24, 1, p, 0, 0, "R5 page");
                end

        // R10: noise during erase
        set_wel();
        do_erase(24'h000300, 6'd24, 1, 3, 1, 0, "R10 noise");

        // R9: lock without wel ignored
        do_lock(3'b010);
        check("R9 lock needs wel", int'(lock_o), 0);

        // R9: lock page 2 with wel
        set_wel();
        do_lock(3'b010);
        check("R9 lock set", int'(lock_o), 3'b010);
        check("R9 wel cleared", int'(wel_o), 0);

        // R6: sweep pages against lock state
        for (int p = 1; p < 4; p++) begin
            set_wel();
            if (p == 2)
                do_erase({14'd0, 2'(p), 8'h3C}, 6'd24, 0, 0, 0, 0, "R6 locked");
            else
                do_erase({14'd0, 2'(p), 8'h3C}, 6'd24, 1, p, 0, 0, "R6 unlocked");
        end

        // R9: OR behaviour and stickiness
        set_wel();
        do_lock(3'b101);
        check("R9 lock or", int'(lock_o), 3'b111);
        set_wel();
        do_lock(3'b000);
        check("R9 lock sticky", int'(lock_o), 3'b111);
        for (int p = 1; p < 4; p++) begin
            set_wel();
            do_erase({14'd0, 2'(p), 8'h00}, 6'd24, 0, 0, 0, 0, "R6 all locked");
        end

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule